// File: doc/BRIEF.md
# Flash Bulk Transfer FIFO Engine

This block sits between a host register interface and the data path of a serial flash. All bulk data moves through one data port in both directions, backed by a single FIFO. For a read, the host loads a start byte address, then writes the control register with a word count and the read-mode bit. A sequencer fetches that many 32-bit words from the flash model into the FIFO and holds a busy flag until the last one has landed. The host then drains the words by reading the data port repeatedly, one word per access. Writing zero to the control register ends the burst before the next one is programmed. Host software splits large transfers into blocks no bigger than the FIFO and runs one address/count/busy sequence per block.

For the write direction, the host pushes words into the same data port and watches a free-space field in the control register. It waits until the field shows the full depth, then pushes up to that many words. A behavioural flash model stands in for the device. It returns read data with a fixed latency from an address-derived pattern. It absorbs pushed write data once the host has left the data port alone for a quiet window.

Top module: `flash_fifo_engine`

## Requirements
- R1: Register map by `csr_addr`: 0 control, 1 flash byte address, 2 FIFO data port, 3 reads zero. Control fields: [9:0] read count, [12] read mode, [13] busy, [14] underflow, [15] overflow, [22:16] free FIFO space in words. After reset the control register reads 0x0040_0000 (space 64, all else clear) and the address register reads 0.
- R2: Write the address, then write control with bit 12 set and a count N from 1 to 64. Busy is set from the cycle after that write until all N words are in the FIFO. Successive data-port reads then return pattern(A+4k) for k = 0..N-1, where pattern(a) = {a[15:0] ^ 16'h5AA5, a[15:0]}.
- R3: Every host read returns its data on `csr_rdata` with `csr_rvalid` high in the cycle after `csr_rd`. The free-space field seen by a read issued in the cycle after a push or pop already includes that push or pop.
- R4: A control write with the read-mode bit set and a count of zero keeps busy clear and fetches nothing. The mode bit reads back as 1.
- R5: A data-port read from an empty FIFO returns zero and sets the sticky underflow bit.
- R6: A data-port write is dropped, and the sticky overflow bit is set, when the FIFO is full or a read burst is busy.
- R7: Writing zero to the control register clears count, mode, busy, underflow and overflow, and empties the FIFO. It also aborts a running burst, so no fetched word from it lands later.
- R8: Data-port writes are kept in push order and can be read back through the data port in that order. After 16 cycles with no data-port access, the flash model absorbs the held words one per cycle until the free space is back at 64.
- R9: While the read-mode bit is set, the flash model absorbs no pushed words.
- R10: A nonzero control write while busy is ignored: the running burst keeps its count and address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_rd | input | 1 | Register read strobe |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid with csr_rvalid |
| csr_rvalid | output | 1 | Read data valid, one cycle after csr_rd |

## Verification
Register and data-port reads return data exactly one cycle after the strobe. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge. FIFO occupancy and the sticky bits are updated at the edge that takes a push, pop or control write, so a control read issued right after such an access must already show the change, and the bench checks it there. Burst completion has no fixed cycle count because of the fetch latency. The bench therefore polls busy and compares the free space and drained words only after busy reads clear. The flash model's absorption of pushed words begins 16 quiet cycles after the last data-port access. Checks that expect held words are made well inside that window, and checks that expect absorption are made after waiting well past it.

// File: rtl/ffe_pkg.sv
package ffe_pkg;

  // Control register bit positions (host software decodes these)
  localparam int MODE_BIT  = 12;
  localparam int BUSY_BIT  = 13;
  localparam int UNDER_BIT = 14;
  localparam int OVER_BIT  = 15;
  localparam int SPACE_LSB = 16;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ADDR = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_e;

  // Content the behavioural flash returns for a byte address
  function automatic logic [31:0] flash_pattern(input logic [31:0] a);
    return {a[15:0] ^ 16'h5AA5, a[15:0]};
  endfunction

endpackage

// File: rtl/ffe_fifo.sv
module ffe_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);

  // Storage and registered read port, no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
    if (pop)  rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6: callers must never push into a full FIFO
  assert_no_push_full_R6: assert property (@(posedge clk) disable iff (rst)
    push && !flush |-> !full);

  // R5: callers must never pop an empty FIFO
  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (rst)
    pop && !flush |-> !empty);

endmodule

// File: rtl/ffe_read_seq.sv
module ffe_read_seq import ffe_pkg::*; #(
  parameter int CNT_W = 10,
  parameter int DEPTH = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        abort,
  input  logic [CNT_W-1:0]            cnt_in,
  input  logic [31:0]                 base_addr,
  input  logic [$clog2(DEPTH+1)-1:0]  fifo_count,
  output logic                        req,
  output logic [31:0]                 req_addr,
  input  logic                        resp_valid,
  input  logic [31:0]                 resp_data,
  output logic                        push,
  output logic [31:0]                 push_data,
  output logic                        busy
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  seq_state_e         state;
  logic [CNT_W-1:0]   remain;
  logic [31:0]        cur_addr;

  assign req       = (state == SQ_ISSUE) && (fifo_count < DEPTH_C);
  assign req_addr  = cur_addr;
  assign push      = (state == SQ_WAIT) && resp_valid;
  assign push_data = resp_data;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state    <= SQ_IDLE;
      remain   <= '0;
      cur_addr <= '0;
      busy     <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start && (cnt_in != '0)) begin
            remain   <= cnt_in;
            cur_addr <= base_addr;
            busy     <= 1'b1;
            state    <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (req) state <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (resp_valid) begin
            cur_addr <= cur_addr + 32'd4;
            remain   <= remain - 1'b1;
            if (remain == CNT_W'(1)) begin
              state <= SQ_IDLE;
              busy  <= 1'b0;
            end else begin
              state <= SQ_ISSUE;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R2: busy only drops when the last word arrives or the burst is aborted
  assert_busy_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(resp_valid || abort));

  // R2: a fetched word always finds room in the FIFO
  assert_push_room_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> (fifo_count < DEPTH_C));

  // R4: a zero count never raises busy
  assert_zero_count_R4: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE) && start && (cnt_in == '0) && !abort |=> !busy);

endmodule

// File: rtl/ffe_flash_model.sv
module ffe_flash_model import ffe_pkg::*; #(
  parameter int LAT       = 3,
  parameter int PROG_IDLE = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        abort,
  input  logic        req,
  input  logic [31:0] req_addr,
  output logic        resp_valid,
  output logic [31:0] resp_data,
  input  logic        host_touch,
  input  logic        fifo_empty,
  input  logic        hold,
  output logic        drain_pop
);
  localparam int IW = $clog2(PROG_IDLE+1);
  localparam logic [IW-1:0] IDLE_C = IW'(PROG_IDLE);

  logic [LAT-1:0] vld;
  logic [31:0]    adr [LAT];
  logic [IW-1:0]  quiet;

  // Fixed-latency read pipeline
  always_ff @(posedge clk) begin
    if (rst || abort) vld[0] <= 1'b0;
    else              vld[0] <= req;
    adr[0] <= req_addr;
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || abort) vld[i] <= 1'b0;
      else              vld[i] <= vld[i-1];
      adr[i] <= adr[i-1];
    end
  end

  assign resp_valid = vld[LAT-1];
  assign resp_data  = flash_pattern(adr[LAT-1]);

  // Write-side absorption after a quiet window on the data port
  always_ff @(posedge clk) begin
    if (rst || host_touch)  quiet <= '0;
    else if (quiet < IDLE_C) quiet <= quiet + 1'b1;
  end

  assign drain_pop = (quiet == IDLE_C) && !fifo_empty && !hold && !host_touch;

  // R8: absorption never directly follows a host data-port access
  assert_drain_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    drain_pop |-> $past(!host_touch));

endmodule

// File: rtl/flash_fifo_engine.sv
module flash_fifo_engine import ffe_pkg::*; #(
  parameter int DEPTH     = 64,
  parameter int CNT_W     = 10,
  parameter int LAT       = 3,
  parameter int PROG_IDLE = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csr_rd,
  input  logic        csr_wr,
  input  logic [1:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        csr_rvalid
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  reg_sel_e          sel, rsel_q;
  logic              ctrl_wr, clr, start_req;
  logic              mode_q, under_q, over_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       addr_q, reg_q, ctrl_word;
  logic              host_push_req, host_pop_req, host_push, host_pop;
  logic              under_pop_q, rvalid_q;

  logic              busy, seq_req, seq_push, resp_valid, drain_pop;
  logic [31:0]       seq_req_addr, seq_push_data, resp_data;
  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [31:0]       fifo_wdata, fifo_rdata;
  logic [CW-1:0]     fifo_count;

  assign sel           = reg_sel_e'(csr_addr);
  assign ctrl_wr       = csr_wr && (sel == REG_CTRL);
  assign clr           = ctrl_wr && (csr_wdata == 32'd0);
  assign start_req     = ctrl_wr && csr_wdata[MODE_BIT] && !busy;
  assign host_push_req = csr_wr && (sel == REG_DATA);
  assign host_pop_req  = csr_rd && (sel == REG_DATA);
  assign host_push     = host_push_req && !fifo_full && !busy;
  assign host_pop      = host_pop_req && !fifo_empty;

  assign fifo_push  = seq_push || host_push;
  assign fifo_wdata = seq_push ? seq_push_data : csr_wdata;
  assign fifo_pop   = host_pop || drain_pop;

  // Control and address registers
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mode_q  <= 1'b0;
      cnt_q   <= '0;
      under_q <= 1'b0;
      over_q  <= 1'b0;
    end else begin
      if (start_req) begin
        mode_q <= 1'b1;
        cnt_q  <= csr_wdata[CNT_W-1:0];
      end
      if (host_pop_req && fifo_empty)             under_q <= 1'b1;
      if (host_push_req && (fifo_full || busy))   over_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   addr_q <= '0;
    else if (csr_wr && (sel == REG_ADDR))      addr_q <= csr_wdata;
  end

  always_comb begin
    ctrl_word                       = '0;
    ctrl_word[CNT_W-1:0]            = cnt_q;
    ctrl_word[MODE_BIT]             = mode_q;
    ctrl_word[BUSY_BIT]             = busy;
    ctrl_word[UNDER_BIT]            = under_q;
    ctrl_word[OVER_BIT]             = over_q;
    ctrl_word[SPACE_LSB +: CW]      = DEPTH_C - fifo_count;
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q      <= REG_CTRL;
      rvalid_q    <= 1'b0;
      reg_q       <= '0;
      under_pop_q <= 1'b0;
    end else begin
      rvalid_q <= csr_rd;
      if (csr_rd) begin
        rsel_q      <= sel;
        under_pop_q <= host_pop_req && fifo_empty;
        case (sel)
          REG_CTRL: reg_q <= ctrl_word;
          REG_ADDR: reg_q <= addr_q;
          default:  reg_q <= '0;
        endcase
      end
    end
  end

  assign csr_rdata  = (rsel_q == REG_DATA) ? (under_pop_q ? 32'd0 : fifo_rdata) : reg_q;
  assign csr_rvalid = rvalid_q;

  ffe_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (clr),
    .push  (fifo_push),
    .wdata (fifo_wdata),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  ffe_read_seq #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start_req),
    .abort      (clr),
    .cnt_in     (csr_wdata[CNT_W-1:0]),
    .base_addr  (addr_q),
    .fifo_count (fifo_count),
    .req        (seq_req),
    .req_addr   (seq_req_addr),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .push       (seq_push),
    .push_data  (seq_push_data),
    .busy       (busy)
  );

  ffe_flash_model #(.LAT(LAT), .PROG_IDLE(PROG_IDLE)) u_flash (
    .clk        (clk),
    .rst        (rst),
    .abort      (clr),
    .req        (seq_req),
    .req_addr   (seq_req_addr),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .host_touch (host_push_req || host_pop_req),
    .fifo_empty (fifo_empty),
    .hold       (mode_q || busy),
    .drain_pop  (drain_pop)
  );

  // R3: every read strobe yields valid data on the next cycle
  assert_rvalid_next_R3: assert property (@(posedge clk) disable iff (rst)
    csr_rd |=> csr_rvalid);

  // R5: underflow is sticky until a control clear
  assert_under_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    under_q && !clr |=> under_q);

  // R6: overflow is sticky until a control clear
  assert_over_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    over_q && !clr |=> over_q);

  // R7: a clear leaves an empty FIFO and an idle sequencer
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fifo_count == '0) && !busy && !mode_q);

  // R2: a valid start with a nonzero count raises busy
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (rst)
    start_req && (csr_wdata[CNT_W-1:0] != '0) |=> busy);

  // R9: nothing is absorbed while read mode is set
  assert_no_drain_mode_R9: assert property (@(posedge clk) disable iff (rst)
    drain_pop |-> !mode_q);

endmodule

// File: tb/tb_flash_fifo_engine.sv
module tb_flash_fifo_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam logic [31:0] MODE  = 32'h0000_1000;
  localparam logic [31:0] BUSYB = 32'h0000_2000;
  localparam logic [31:0] UNDB  = 32'h0000_4000;
  localparam logic [31:0] OVRB  = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst;
  logic        csr_rd = 1'b0, csr_wr = 1'b0;
  logic [1:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_rvalid;

  int total = 0, fails = 0;

  flash_fifo_engine dut (
    .clk(clk), .rst(rst), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5AA5, a[15:0]};
  endfunction

  function automatic logic [31:0] space_f(input int n);
    return 32'(n) << 16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_rd = 1'b0;
    d = csr_rdata;
    v = csr_rvalid;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] d;
    logic v;
    bit done = 0;
    for (int i = 0; i < 600; i++) begin
      rd(2'd0, d, v);
      if ((d & BUSYB) == 0) begin done = 1; break; end
    end
    if (!done) chk(req, d & BUSYB, 32'd0);
  endtask

  task automatic burst_check(input string req, input logic [31:0] a, input int n);
    logic [31:0] d;
    logic v;
    wr(2'd1, a);
    wr(2'd0, MODE | 32'(n));
    wait_idle(req);
    rd(2'd0, d, v);
    chk(req, d, MODE | 32'(n) | space_f(DEPTH - n));
    for (int k = 0; k < n; k++) begin
      rd(2'd2, d, v);
      chk(req, d, pat(a + 32'(4 * k)));
    end
    wr(2'd0, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d, a;
    logic v;
    logic [31:0] w [65];
    int n;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd(2'd0, d, v);
    chk("R1 ctrl reset", d, space_f(DEPTH));
    rd(2'd1, d, v);
    chk("R1 addr reset", d, 32'd0);
    // R3: rvalid follows strobe
    chk("R3 rvalid", {31'd0, v}, 32'd1);
    rd(2'd3, d, v);
    chk("R1 unused reg", d, 32'd0);

    // R2: directed bursts at the edges of the count range
    burst_check("R2 single word", 32'h0000_1230, 1);
    burst_check("R2 full depth", 32'h0001_FF00, DEPTH);

    // R2: random bursts
    for (int t = 0; t < 6; t++) begin
      a = $urandom & 32'hFFFF_FFFC;
      n = 1 + int'($urandom % DEPTH);
      burst_check("R2 random burst", a, n);
    end

    // R4: zero count with read mode
    wr(2'd0, MODE);
    rd(2'd0, d, v);
    chk("R4 zero count", d, MODE | space_f(DEPTH));
    // R9: pushes held while mode set
    for (int k = 0; k < 3; k++) wr(2'd2, 32'hA000_0000 + 32'(k));
    repeat (40) @(posedge clk);
    rd(2'd0, d, v);
    chk("R9 no absorb in mode", d, MODE | space_f(DEPTH - 3));
    // R7: clear empties
    wr(2'd0, 32'd0);
    rd(2'd0, d, v);
    chk("R7 clear flush", d, space_f(DEPTH));

    // R8 / R3: push order, immediate space, later absorption
    for (int k = 0; k < 5; k++) begin
      w[k] = $urandom;
      wr(2'd2, w[k]);
    end
    rd(2'd0, d, v);
    chk("R3 space after push", d, space_f(DEPTH - 5));
    rd(2'd2, d, v);
    chk("R8 order w0", d, w[0]);
    rd(2'd2, d, v);
    chk("R8 order w1", d, w[1]);
    rd(2'd0, d, v);
    chk("R3 space after pop", d, space_f(DEPTH - 3));
    repeat (40) @(posedge clk);
    rd(2'd0, d, v);
    chk("R8 absorbed", d, space_f(DEPTH));

    // R6 / R5: overflow on full, then underflow
    for (int k = 0; k < 65; k++) begin
      w[k] = $urandom;
      wr(2'd2, w[k]);
    end
    rd(2'd0, d, v);
    chk("R6 overflow full", d, OVRB | space_f(0));
    for (int k = 0; k < 64; k++) begin
      rd(2'd2, d, v);
      chk("R6 kept words", d, w[k]);
    end
    rd(2'd2, d, v);
    chk("R5 empty pop zero", d, 32'd0);
    rd(2'd0, d, v);
    chk("R5 underflow sticky", d, UNDB | OVRB | space_f(DEPTH));
    wr(2'd0, 32'd0);
    rd(2'd0, d, v);
    chk("R7 sticky clear", d, space_f(DEPTH));

    // R6: push during busy dropped
    wr(2'd1, 32'h0000_0040);
    wr(2'd0, MODE | 32'd40);
    wr(2'd2, 32'hDEAD_BEEF);
    wait_idle("R6 busy push");
    rd(2'd0, d, v);
    chk("R6 push while busy", d, MODE | 32'd40 | OVRB | space_f(DEPTH - 40));
    rd(2'd2, d, v);
    chk("R6 first word intact", d, pat(32'h0000_0040));
    wr(2'd0, 32'd0);

    // R10: restart while busy ignored
    wr(2'd1, 32'h0000_3000);
    wr(2'd0, MODE | 32'd8);
    wr(2'd0, MODE | 32'd30);
    wait_idle("R10");
    rd(2'd0, d, v);
    chk("R10 ignore restart", d, MODE | 32'd8 | space_f(DEPTH - 8));
    rd(2'd2, d, v);
    chk("R10 original addr", d, pat(32'h0000_3000));
    wr(2'd0, 32'd0);

    // R7: abort mid-burst, then a fresh burst must be clean
    wr(2'd1, 32'h0000_0100);
    wr(2'd0, MODE | 32'd20);
    wr(2'd0, 32'd0);
    rd(2'd0, d, v);
    chk("R7 abort idle", d, space_f(DEPTH));
    burst_check("R7 after abort", 32'h0000_2000, 4);
    repeat (20) @(posedge clk);
    rd(2'd0, d, v);
    chk("R7 no stale word", d, space_f(DEPTH));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule